// File: doc/BRIEF.md
# Serial Frame Loader with Command Decode

This block takes a serial frame on a single data pin and a slow serial clock. It shifts in one bit on each falling edge of that serial clock. Each frame is 68 bits long. Its first 60 bits are one row of display pixels and its last 8 bits are a command byte. The serial clock is treated as asynchronous: it is brought into the system clock domain and its edges are detected there.

There is no chip select. A frame takes effect when the serial clock has stayed low for a programmable number of system clock cycles. At that point the 60 pixel bits go into one row of an 8-row display memory, and the command byte updates the configuration outputs:
- row count (2, 4 or 8),
- column-only operation,
- blank,
- set (all on),
- a resynchronisation pulse for the row sequencer.

A cascade output repeats the serial data 68 falling edges later, so several loaders can be chained. A drive sequencer reads any row of the memory through an asynchronous read port.

Top module: `serial_frame_loader`

## Requirements
- R1: Frame bit 67 is shifted in first and bit 0 last. After a commit, the addressed memory row holds frame bits 67..8, with read bit k equal to frame bit k+8.
- R2: The data input is sampled only on falling edges of `sclk_i`. Data changes while `sclk_i` stays at one level are not captured.
- R3: After each falling edge, `casc_o` equals the data bit sampled 68 falling edges earlier. It does not change between falling edges.
- R4: A commit happens only after `sclk_i` has stayed low for STROBE_CYCLES system clocks following at least one falling edge. Any edge of `sclk_i` restarts the count, and no commit happens while `sclk_i` is high. The configuration outputs change only at a commit.
- R5: The row written is the 3-bit value {cmd[3], cmd[4], cmd[5]}, with cmd[3] as the most significant bit.
- R6: `mux_mode_o` encodes the row count as 0 = 2 rows, 1 = 4 rows, 2 = 8 rows. These are set by cmd[1:0] as follows:
  - cmd[1:0] = 00 gives 0.
  - cmd[1:0] = 10 gives 1.
  - cmd[1:0] = 11 gives 2.
  - cmd[1:0] = 01 keeps the previous mode, and the rest of the frame is still applied.
- R7: On commit, `blank_o` becomes cmd[6] AND NOT cmd[7], and `set_o` becomes cmd[7] AND NOT cmd[6].
- R8: A command with cmd[6] and cmd[7] both 1 gives a one-cycle pulse on `sync_o`. It leaves `blank_o` and `set_o` at 0, and the pixel row is still written.
- R9: On commit, `col_only_o` becomes NOT cmd[2]: cmd[2] = 1 selects row-and-column driving.
- R10: After reset, these outputs are all 0: `mux_mode_o`, `col_only_o`, `blank_o`, `set_o`, `sync_o` and `casc_o`.
- R11: A commit writes only the addressed row. All other rows keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data |
| rd_row_i | input | 3 | Read row index for the drive sequencer |
| casc_o | output | 1 | Cascade data output |
| mux_mode_o | output | 2 | Row count code |
| col_only_o | output | 1 | Column-only operation |
| blank_o | output | 1 | Force all columns off |
| set_o | output | 1 | Force all columns on |
| sync_o | output | 1 | Row sequencer resynchronisation pulse |
| rd_data_o | output | 60 | Pixel row at rd_row_i (asynchronous read) |

## Verification
Timing of each result:
- **Cascade output:** a serial clock edge reaches the edge detector after two synchroniser flops, so `casc_o` changes three system clocks after `sclk_i` falls. The bench therefore samples it at the end of each six-cycle low phase.
- **Configuration outputs and memory row:** these follow the last falling edge by the synchroniser delay, plus STROBE_CYCLES of low time, plus one register stage. The bench waits STROBE_CYCLES+12 cycles before checking them, and polls `sync_o` every cycle in that window so the one-cycle pulse is counted exactly once.
- **No early commit:** the strobe test holds the clock low for four cycles less than the threshold, then high for a hundred cycles. It checks, before any later fall, that the old row contents are still present.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {
    MUX_2ROW = 2'd0,
    MUX_4ROW = 2'd1,
    MUX_8ROW = 2'd2
  } mux_e;

  typedef struct packed {
    logic valid;
    mux_e mode;
  } mux_dec_t;

  function automatic mux_dec_t decode_mux(input logic [1:0] code);
    mux_dec_t r;
    r.valid = 1'b1;
    r.mode  = MUX_2ROW;
    case (code)
      2'b00:   r.mode = MUX_2ROW;
      2'b10:   r.mode = MUX_4ROW;
      2'b11:   r.mode = MUX_8ROW;
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sfl_edge_sync.sv
module sfl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic fall_o,
  output logic rise_o,
  output logic low_o,
  output logic data_o
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], sclk_i};
      dat_pipe <= {dat_pipe[STAGES-2:0], sdata_i};
      clk_prev <= clk_pipe[STAGES-1];
    end
  end

  assign fall_o = clk_prev & ~clk_pipe[STAGES-1];
  assign rise_o = ~clk_prev & clk_pipe[STAGES-1];
  assign low_o  = ~clk_pipe[STAGES-1];
  assign data_o = dat_pipe[STAGES-1];
endmodule

// File: rtl/sfl_frame_shift.sv
module sfl_frame_shift #(
  parameter int FRAME_BITS = 68
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_i,
  input  logic                  bit_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  casc_o
);
  logic [FRAME_BITS-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      casc_o <= 1'b0;
    end else if (shift_i) begin
      sreg   <= {sreg[FRAME_BITS-2:0], bit_i};
      casc_o <= sreg[FRAME_BITS-1];
    end
  end

  assign frame_o = sreg;
endmodule

// File: rtl/sfl_strobe_timer.sv
module sfl_strobe_timer #(
  parameter int STROBE_CYCLES = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic rise_i,
  input  logic low_i,
  output logic commit_o
);
  localparam int CW = $clog2(STROBE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      armed    <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (fall_i) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (rise_i) begin
        cnt <= '0;
      end else if (armed && low_i) begin
        if (cnt == CW'(STROBE_CYCLES - 1)) begin
          commit_o <= 1'b1;
          armed    <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfl_row_mem.sv
module sfl_row_mem #(
  parameter int ROWS  = 8,
  parameter int WIDTH = 60,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/serial_frame_loader.sv
module serial_frame_loader
  import sfl_pkg::*;
#(
  parameter int FRAME_BITS    = 68,
  parameter int CMD_BITS      = 8,
  parameter int ROWS          = 8,
  parameter int STROBE_CYCLES = 600,
  localparam int COLS         = FRAME_BITS - CMD_BITS,
  localparam int AW           = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic [AW-1:0]   rd_row_i,
  output logic            casc_o,
  output logic [1:0]      mux_mode_o,
  output logic            col_only_o,
  output logic            blank_o,
  output logic            set_o,
  output logic            sync_o,
  output logic [COLS-1:0] rd_data_o
);
  logic                  fall_w;
  logic                  rise_w;
  logic                  sclk_lo_w;
  logic                  bit_w;
  logic                  commit_w;
  logic [FRAME_BITS-1:0] frame_w;
  logic [CMD_BITS-1:0]   cmd_w;
  logic [AW-1:0]         row_w;
  mux_dec_t              mux_dec;

  sfl_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .fall_o(fall_w), .rise_o(rise_w), .low_o(sclk_lo_w), .data_o(bit_w)
  );

  sfl_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst), .shift_i(fall_w), .bit_i(bit_w),
    .frame_o(frame_w), .casc_o(casc_o)
  );

  sfl_strobe_timer #(.STROBE_CYCLES(STROBE_CYCLES)) u_strobe (
    .clk(clk), .rst(rst), .fall_i(fall_w), .rise_i(rise_w),
    .low_i(sclk_lo_w), .commit_o(commit_w)
  );

  assign cmd_w   = frame_w[CMD_BITS-1:0];
  assign mux_dec = decode_mux(cmd_w[1:0]);

  // row index: bit 3 is the most significant address bit
  generate
    for (genvar i = 0; i < AW; i++) begin : g_row
      assign row_w[AW-1-i] = cmd_w[3+i];
    end
  endgenerate

  sfl_row_mem #(.ROWS(ROWS), .WIDTH(COLS)) u_mem (
    .clk(clk), .we_i(commit_w), .waddr_i(row_w),
    .wdata_i(frame_w[FRAME_BITS-1:CMD_BITS]),
    .raddr_i(rd_row_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_mode_o <= MUX_2ROW;
      col_only_o <= 1'b0;
      blank_o    <= 1'b0;
      set_o      <= 1'b0;
      sync_o     <= 1'b0;
    end else begin
      sync_o <= 1'b0;
      if (commit_w) begin
        if (mux_dec.valid) mux_mode_o <= mux_dec.mode;
        col_only_o <= ~cmd_w[2];
        blank_o    <= cmd_w[6] & ~cmd_w[7];
        set_o      <= cmd_w[7] & ~cmd_w[6];
        sync_o     <= cmd_w[6] & cmd_w[7];
      end
    end
  end
endmodule

// File: rtl/serial_frame_loader_chk.sv
module serial_frame_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       fall,
  input logic       commit,
  input logic       sclk_lo,
  input logic       casc,
  input logic [1:0] mux,
  input logic       col,
  input logic       blank,
  input logic       set,
  input logic       sync
);
  AST_MUX_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) mux != 2'd3); // R6
  AST_BLANK_SET_EXCL: assert property (@(posedge clk) disable iff (rst) !(blank && set)); // R7
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) sync |=> !sync); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(mux) && $stable(col) && $stable(blank) && $stable(set))); // R4
  AST_COMMIT_WHILE_LOW: assert property (@(posedge clk) disable iff (rst) commit |-> $past(sclk_lo)); // R4
  AST_CASC_HOLD: assert property (@(posedge clk) disable iff (rst) !fall |=> $stable(casc)); // R3
endmodule

bind serial_frame_loader serial_frame_loader_chk u_chk (
  .clk(clk), .rst(rst), .fall(fall_w), .commit(commit_w), .sclk_lo(sclk_lo_w),
  .casc(casc_o), .mux(mux_mode_o), .col(col_only_o), .blank(blank_o),
  .set(set_o), .sync(sync_o)
);

// File: tb/serial_frame_loader_tb.sv
`timescale 1ns/1ps
module serial_frame_loader_tb;
  localparam int STROBE = 20;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic [2:0] rd_row = 3'd0;
  logic casc, col_only, blank, set_w, sync;
  logic [1:0] mux;
  logic [59:0] rd_data;

  int checks = 0;
  int errors = 0;
  int sync_seen = 0;
  logic [67:0] last_frame = '0;

  always #5 clk = ~clk;

  serial_frame_loader #(.STROBE_CYCLES(STROBE)) u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .rd_row_i(rd_row),
    .casc_o(casc), .mux_mode_o(mux), .col_only_o(col_only), .blank_o(blank),
    .set_o(set_w), .sync_o(sync), .rd_data_o(rd_data)
  );

  // entry: data[75:16] cmd[15:8] row[7:5] mux[4:3] col[2] blank[1] set[0]
  localparam logic [75:0] VEC [NV] = '{
    {60'h123456789ABCDEF, 8'h07, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0},
    {60'hFEDCBA987654321, 8'h27, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0},
    {60'h0F0F0F0F0F0F0F0, 8'h0E, 3'd4, 2'd1, 1'b0, 1'b0, 1'b0},
    {60'hFFFFFFFFFFFFFFF, 8'h43, 3'd0, 2'd2, 1'b1, 1'b1, 1'b0},
    {60'h800000000000001, 8'h99, 3'd6, 2'd2, 1'b1, 1'b0, 1'b1},
    {60'h555555555555555, 8'h3A, 3'd7, 2'd1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int hi, input int lo);
    @(posedge clk); #1;
    sdata = b; sclk = 1'b1;
    repeat (hi) @(posedge clk);
    #1 sclk = 1'b0;
    repeat (lo) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [67:0] f);
    for (int i = 67; i >= 0; i--) begin
      send_bit(f[i], 6, 6);
      chk("R3 cascade", {63'd0, casc}, {63'd0, last_frame[i]});
    end
    last_frame = f;
  endtask

  task automatic wait_commit();
    sync_seen = 0;
    for (int c = 0; c < STROBE + 12; c++) begin
      @(posedge clk); #1;
      if (sync) sync_seen++;
    end
  endtask

  task automatic read_row(input logic [2:0] r, output logic [59:0] d);
    rd_row = r; #1; d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [59:0] d;
    logic [67:0] fk, fh, fg;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R10 reset mux", {62'd0, mux}, 64'd0);
    chk("R10 reset flags", {60'd0, col_only, blank, set_w, sync}, 64'd0);
    chk("R10 reset casc", {63'd0, casc}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][75:8]);
      wait_commit();
      read_row(VEC[v][7:5], d);
      chk("R1 R5 row data", {4'd0, d}, {4'd0, VEC[v][75:16]});
      chk("R6 mux mode", {62'd0, mux}, {62'd0, VEC[v][4:3]});
      chk("R9 col only", {63'd0, col_only}, {63'd0, VEC[v][2]});
      chk("R7 blank", {63'd0, blank}, {63'd0, VEC[v][1]});
      chk("R7 set", {63'd0, set_w}, {63'd0, VEC[v][0]});
      chk("R8 no sync", sync_seen, 0);
    end

    read_row(3'd0, d); chk("R11 row0 kept", {4'd0, d}, {4'd0, 60'hFFFFFFFFFFFFFFF});
    read_row(3'd1, d); chk("R11 row1 kept", {4'd0, d}, {4'd0, 60'hFEDCBA987654321});
    read_row(3'd4, d); chk("R11 row4 kept", {4'd0, d}, {4'd0, 60'h0F0F0F0F0F0F0F0});
    read_row(3'd6, d); chk("R11 row6 kept", {4'd0, d}, {4'd0, 60'h800000000000001});

    // R8 set plus blank gives resync pulse, row still written
    fg = {60'h0000000000000AA, 8'hC7};
    send_frame(fg);
    wait_commit();
    chk("R8 sync pulse count", sync_seen, 1);
    chk("R8 blank set clear", {62'd0, blank, set_w}, 64'd0);
    read_row(3'd0, d); chk("R8 row0 written", {4'd0, d}, {4'd0, 60'h0000000000000AA});
    read_row(3'd7, d); chk("R11 row7 kept", {4'd0, d}, {4'd0, 60'h555555555555555});

    // R4 strobe: seed row2, then a frame with short low gaps and long high gaps
    fk = {60'h3C3C3C3C3C3C3C3, 8'h17};
    send_frame(fk);
    wait_commit();
    read_row(3'd2, d); chk("R5 row2 seed", {4'd0, d}, {4'd0, 60'h3C3C3C3C3C3C3C3});
    chk("R6 mux after seed", {62'd0, mux}, 64'd2);
    fh = {60'hC3C3C3C3C3C3C3C, 8'h17};
    for (int i = 67; i >= 30; i--) send_bit(fh[i], 6, STROBE - 4);
    read_row(3'd2, d); chk("R4 short low no commit", {4'd0, d}, {4'd0, 60'h3C3C3C3C3C3C3C3});
    for (int i = 29; i >= 1; i--) send_bit(fh[i], 100, 6);
    @(posedge clk); #1 sdata = fh[0]; sclk = 1'b1;
    repeat (100) @(posedge clk); #1;
    read_row(3'd2, d); chk("R4 high no commit", {4'd0, d}, {4'd0, 60'h3C3C3C3C3C3C3C3});
    sclk = 1'b0;
    // R2 data toggles with clock low must not be captured
    repeat (3) @(posedge clk); #1 sdata = ~fh[0];
    wait_commit();
    read_row(3'd2, d); chk("R4 R2 commit after strobe", {4'd0, d}, {4'd0, 60'hC3C3C3C3C3C3C3C});
    chk("R9 col after strobe", {63'd0, col_only}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule